// File: doc/BRIEF.md
# Synchronous Serial Slave Receiver

This block is a receive-only serial port that works as the slave of a synchronous link. An external master drives both a shift clock and a data line. The block samples the data line on the edge of that clock chosen by a polarity bit, least significant bit first, and assembles eight or nine bits in a shift register. When a word is complete it is moved into a holding register and a receive-done flag is raised. Software then reads the status register for the ninth bit and the overrun flag, and reads the data register, which clears the done flag.

The external clock and data are brought into the system clock domain through a synchronizer chain with edge detection. No baud generator is involved, so a word can complete while the host core is asleep. A pending, enabled receive then raises a wake request. The interrupt line needs the receive enable, a peripheral enable and a global enable. If a second word completes while the first is still unread, the overrun flag is set, the new word is dropped and reception stops. Only clearing the continuous-receive enable clears the overrun.

Top module: `sync_slave_rx`

## Requirements
- R1: After reset the control register (address 0), status register (address 1), data register (address 2) and interrupt-enable register (address 3) all read 0, and the interrupt and wake outputs are 0. Unmapped addresses read 0, and the framing bit (status bit 2) always reads 0.
- R2: Reception runs only when control bits port enable [0], synchronous mode [1] and continuous receive [4] are set and clock-source master [2] is clear. Otherwise clock edges leave the done flag (status bit 3) at 0.
- R3: In eight-bit mode (control bit 3 clear) eight bits sampled LSB first appear in the data register, and the done flag (status bit 3) is set when the word completes.
- R4: In nine-bit mode (control bit 3 set) nine bits are received LSB first. The low eight go to the data register and the ninth goes to status bit 0. In eight-bit mode status bit 0 reads 0.
- R5: With control bit 6 clear, data is sampled on rising edges of the external clock. With it set, data is sampled on falling edges.
- R6: The single-receive control bit [5] has no effect: it neither enables reception without bit 4 nor alters reception with bit 4 set.
- R7: A read of the data register clears the done flag.
- R8: If a word completes while the done flag is set, the overrun bit (status bit 1) is set and the data register keeps the old word. Later words are blocked while the overrun bit is set.
- R9: Clearing control bit 4 clears the overrun bit and discards a partly received word. Reception restarts at bit 0 when bit 4 is set again.
- R10: The interrupt output is high only when the done flag and interrupt-enable bits receive [0], peripheral [1] and global [2] are all set.
- R11: The wake output is high when the sleep input, the done flag and the receive interrupt-enable bit [0] are all set, regardless of the peripheral and global bits.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| ser_clk_i | input | 1 | Shift clock from the external master |
| ser_data_i | input | 1 | Serial data from the external master |
| sleep_i | input | 1 | Host core is asleep |
| reg_addr | input | ADDR_W | Register address |
| reg_wr | input | 1 | Register write strobe |
| reg_rd | input | 1 | Register read strobe (a data read clears the done flag) |
| reg_wdata | input | DATA_W | Register write data |
| reg_rdata | output | DATA_W | Register read data, combinational from the address |
| irq_o | output | 1 | Receive interrupt |
| wake_o | output | 1 | Wake request to the sleeping core |

## Verification
Random byte and nine-bit values are sent with both clock polarities and both word lengths. This separates bit-order, ninth-bit placement and sampling-edge faults, because a wrong edge or a wrong order gives a different value. Directed sequences cover each mode bit that must block reception, with the single-receive bit both set and clear, to separate true enables from ignored ones. A chain of unread words checks the overrun, the discarded data and the blocking. A partial word followed by toggling the continuous enable checks the restart. Combinations of enable bits and the sleep input separate the interrupt gating from the wake gating.

// File: rtl/sync_slave_rx_pkg.sv
package sync_slave_rx_pkg;

   localparam int unsigned ADDR_CTRL = 0;
   localparam int unsigned ADDR_STAT = 1;
   localparam int unsigned ADDR_DATA = 2;
   localparam int unsigned ADDR_IEN  = 3;

   localparam int unsigned CTRL_BITS = 7;
   localparam int unsigned IEN_BITS  = 3;
   localparam int unsigned STAT_BITS = 4;

   // bit 0 is the last field
   typedef struct packed {
      logic pol;     // 1: sample on falling edge
      logic single;  // single-word receive, ignored in slave mode
      logic cont;    // continuous receive enable
      logic nine;    // nine-bit words
      logic msel;    // clock source is local (master)
      logic sync;    // synchronous mode
      logic en;      // port enable
   } ctrl_t;

   typedef struct packed {
      logic gie;
      logic pie;
      logic rie;
   } ien_t;

endpackage

// File: rtl/sync_slave_rx_sync.sv
module sync_slave_rx_sync #(
   parameter int STAGES = 2
) (
   input  logic clk,
   input  logic rst_n,
   input  logic ser_clk,
   input  logic ser_data,
   input  logic pol,
   output logic sample,
   output logic bit_val
);

   generate
      if (STAGES < 2) begin : g_bad_stages
         $error("sync_slave_rx_sync: STAGES must be at least 2");
      end
   endgenerate

   logic [STAGES-1:0] clk_q;
   logic [STAGES-1:0] dat_q;
   logic              clk_prev;
   logic              clk_s;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         clk_q    <= '0;
         dat_q    <= '0;
         clk_prev <= 1'b0;
      end else begin
         clk_q    <= {clk_q[STAGES-2:0], ser_clk};
         dat_q    <= {dat_q[STAGES-2:0], ser_data};
         clk_prev <= clk_q[STAGES-1];
      end
   end

   assign clk_s   = clk_q[STAGES-1];
   assign sample  = pol ? (clk_prev & ~clk_s) : (~clk_prev & clk_s);
   assign bit_val = dat_q[STAGES-1];

endmodule

// File: rtl/sync_slave_rx_shift.sv
module sync_slave_rx_shift #(
   parameter int DATA_W = 8
) (
   input  logic            clk,
   input  logic            rst_n,
   input  logic            run,
   input  logic            nine,
   input  logic            sample,
   input  logic            din,
   output logic            done,
   output logic [DATA_W:0] word
);

   localparam int WORD_W = DATA_W + 1;
   localparam int CNT_W  = $clog2(WORD_W);

   logic [CNT_W-1:0] cnt;
   logic [CNT_W-1:0] last;

   assign last = nine ? CNT_W'(DATA_W) : CNT_W'(DATA_W - 1);

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         cnt  <= '0;
         done <= 1'b0;
         word <= '0;
      end else begin
         done <= 1'b0;
         if (!run) begin
            cnt <= '0;
         end else if (sample) begin
            word[cnt] <= din;
            if (cnt == last) begin
               cnt  <= '0;
               done <= 1'b1;
            end else begin
               cnt <= cnt + 1'b1;
            end
         end
      end
   end

endmodule

// File: rtl/sync_slave_rx_regs.sv
module sync_slave_rx_regs
   import sync_slave_rx_pkg::*;
#(
   parameter int DATA_W   = 8,
   parameter int ADDR_W   = 3,
   parameter bit NINTH_EN = 1'b1
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic [ADDR_W-1:0] addr,
   input  logic              wr,
   input  logic              rd,
   input  logic [DATA_W-1:0] wdata,
   input  logic              word_done,
   input  logic [DATA_W:0]   word,
   input  logic              sleep,
   output logic [DATA_W-1:0] rdata,
   output logic              run,
   output logic              pol,
   output logic              nine_eff,
   output logic              irq,
   output logic              wake,
   output logic              flag,
   output logic              ovr,
   output logic              cont_en,
   output logic              rd_data,
   output logic [DATA_W-1:0] hold_data
);

   generate
      if (DATA_W < CTRL_BITS) begin : g_bad_width
         $error("sync_slave_rx_regs: DATA_W too small for the control register");
      end
      if (ADDR_W < 2) begin : g_bad_addr
         $error("sync_slave_rx_regs: ADDR_W must be at least 2");
      end
   endgenerate

   ctrl_t ctrl;
   ien_t  ien;
   logic  bit9;
   logic  wr_ctrl;
   logic  wr_ien;
   logic  unused_wdata;

   assign wr_ctrl = wr && (addr == ADDR_W'(ADDR_CTRL));
   assign wr_ien  = wr && (addr == ADDR_W'(ADDR_IEN));
   assign rd_data = rd && (addr == ADDR_W'(ADDR_DATA));
   assign unused_wdata = ^wdata[DATA_W-1:CTRL_BITS];

   generate
      if (NINTH_EN) begin : g_ninth
         assign nine_eff = ctrl.nine;
      end else begin : g_no_ninth
         logic unused_nine;
         assign unused_nine = ctrl.nine;
         assign nine_eff    = 1'b0;
      end
   endgenerate

   assign cont_en = ctrl.cont;
   assign pol     = ctrl.pol;
   assign run     = ctrl.en & ctrl.sync & ~ctrl.msel & ctrl.cont & ~ovr;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         ctrl <= '0;
         ien  <= '0;
      end else begin
         if (wr_ctrl) ctrl <= ctrl_t'(wdata[CTRL_BITS-1:0]);
         if (wr_ien)  ien  <= ien_t'(wdata[IEN_BITS-1:0]);
      end
   end

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         hold_data <= '0;
         bit9      <= 1'b0;
         flag      <= 1'b0;
         ovr       <= 1'b0;
      end else begin
         if (word_done) begin
            if (flag && !rd_data) begin
               ovr <= 1'b1;
            end else begin
               hold_data <= word[DATA_W-1:0];
               bit9      <= nine_eff & word[DATA_W];
               flag      <= 1'b1;
            end
         end else if (rd_data) begin
            flag <= 1'b0;
         end
         if (!ctrl.cont) ovr <= 1'b0;
      end
   end

   always_comb begin
      rdata = '0;
      unique case (addr)
         ADDR_W'(ADDR_CTRL): rdata = {{(DATA_W-CTRL_BITS){1'b0}}, ctrl};
         ADDR_W'(ADDR_STAT): rdata = {{(DATA_W-STAT_BITS){1'b0}}, flag, 1'b0, ovr, bit9};
         ADDR_W'(ADDR_DATA): rdata = hold_data;
         ADDR_W'(ADDR_IEN):  rdata = {{(DATA_W-IEN_BITS){1'b0}}, ien};
         default:            rdata = '0;
      endcase
   end

   assign irq  = flag & ien.rie & ien.pie & ien.gie;
   assign wake = sleep & flag & ien.rie;

endmodule

// File: rtl/sync_slave_rx.sv
module sync_slave_rx #(
   parameter int DATA_W      = 8,
   parameter int ADDR_W      = 3,
   parameter int SYNC_STAGES = 2,
   parameter bit NINTH_EN    = 1'b1
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              ser_clk_i,
   input  logic              ser_data_i,
   input  logic              sleep_i,
   input  logic [ADDR_W-1:0] reg_addr,
   input  logic              reg_wr,
   input  logic              reg_rd,
   input  logic [DATA_W-1:0] reg_wdata,
   output logic [DATA_W-1:0] reg_rdata,
   output logic              irq_o,
   output logic              wake_o
);

   logic              sample;
   logic              bit_val;
   logic              run;
   logic              pol;
   logic              nine_eff;
   logic              word_done;
   logic [DATA_W:0]   word;
   logic              flag;
   logic              ovr;
   logic              cont_en;
   logic              rd_data;
   logic [DATA_W-1:0] hold_data;

   sync_slave_rx_sync #(.STAGES(SYNC_STAGES)) u_sync (
      .clk      (clk),
      .rst_n    (rst_n),
      .ser_clk  (ser_clk_i),
      .ser_data (ser_data_i),
      .pol      (pol),
      .sample   (sample),
      .bit_val  (bit_val)
   );

   sync_slave_rx_shift #(.DATA_W(DATA_W)) u_shift (
      .clk    (clk),
      .rst_n  (rst_n),
      .run    (run),
      .nine   (nine_eff),
      .sample (sample),
      .din    (bit_val),
      .done   (word_done),
      .word   (word)
   );

   sync_slave_rx_regs #(
      .DATA_W   (DATA_W),
      .ADDR_W   (ADDR_W),
      .NINTH_EN (NINTH_EN)
   ) u_regs (
      .clk       (clk),
      .rst_n     (rst_n),
      .addr      (reg_addr),
      .wr        (reg_wr),
      .rd        (reg_rd),
      .wdata     (reg_wdata),
      .word_done (word_done),
      .word      (word),
      .sleep     (sleep_i),
      .rdata     (reg_rdata),
      .run       (run),
      .pol       (pol),
      .nine_eff  (nine_eff),
      .irq       (irq_o),
      .wake      (wake_o),
      .flag      (flag),
      .ovr       (ovr),
      .cont_en   (cont_en),
      .rd_data   (rd_data),
      .hold_data (hold_data)
   );

endmodule

// File: rtl/sync_slave_rx_chk.sv
module sync_slave_rx_chk #(
   parameter int DATA_W = 8
) (
   input logic              clk,
   input logic              rst_n,
   input logic              irq_o,
   input logic              wake_o,
   input logic              sleep_i,
   input logic              flag,
   input logic              ovr,
   input logic              word_done,
   input logic              cont_en,
   input logic              rd_data,
   input logic [DATA_W-1:0] hold_data
);

   AST_FLAG_FROM_WORD: assert property (@(posedge clk) disable iff (!rst_n)
      $rose(flag) |-> $past(word_done)); // R3

   AST_READ_CLEARS_FLAG: assert property (@(posedge clk) disable iff (!rst_n)
      (rd_data && !word_done) |=> !flag); // R7

   AST_OVERRUN_FREEZES_DATA: assert property (@(posedge clk) disable iff (!rst_n)
      ovr |=> $stable(hold_data)); // R8

   AST_OVERRUN_CLEARED: assert property (@(posedge clk) disable iff (!rst_n)
      !cont_en |=> !ovr); // R9

   AST_IRQ_NEEDS_FLAG: assert property (@(posedge clk) disable iff (!rst_n)
      irq_o |-> flag); // R10

   AST_WAKE_NEEDS_SLEEP: assert property (@(posedge clk) disable iff (!rst_n)
      wake_o |-> (sleep_i && flag)); // R11

endmodule

bind sync_slave_rx sync_slave_rx_chk #(.DATA_W(DATA_W)) u_chk (
   .clk       (clk),
   .rst_n     (rst_n),
   .irq_o     (irq_o),
   .wake_o    (wake_o),
   .sleep_i   (sleep_i),
   .flag      (flag),
   .ovr       (ovr),
   .word_done (word_done),
   .cont_en   (cont_en),
   .rd_data   (rd_data),
   .hold_data (hold_data)
);

// File: tb/sync_slave_rx_test.sv
`timescale 1ns/1ps
module sync_slave_rx_test;

   localparam int HALF = 6;

   logic       clk = 1'b0;
   logic       rst_n = 1'b0;
   logic       ser_clk = 1'b0;
   logic       ser_data = 1'b0;
   logic       sleep = 1'b0;
   logic [2:0] addr = '0;
   logic       wr = 1'b0;
   logic       rd = 1'b0;
   logic [7:0] wdata = '0;
   logic [7:0] rdata;
   logic       irq;
   logic       wake;

   int checks = 0;
   int fails  = 0;
   bit finished = 1'b0;

   always #4 clk = ~clk;

   sync_slave_rx uut (
      .clk        (clk),
      .rst_n      (rst_n),
      .ser_clk_i  (ser_clk),
      .ser_data_i (ser_data),
      .sleep_i    (sleep),
      .reg_addr   (addr),
      .reg_wr     (wr),
      .reg_rd     (rd),
      .reg_wdata  (wdata),
      .reg_rdata  (rdata),
      .irq_o      (irq),
      .wake_o     (wake)
   );

   function automatic logic [7:0] cfg(bit nine, bit pol, bit cont, bit single, bit msel);
      return {1'b0, pol, single, cont, nine, msel, 1'b1, 1'b1};
   endfunction

   function automatic logic [7:0] stat_exp(bit flag, bit ovr, bit b9);
      return {4'b0, flag, 1'b0, ovr, b9};
   endfunction

   task automatic check(string req, logic [31:0] act, logic [31:0] exp);
      checks++;
      if (act !== exp) begin
         fails++;
         $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
      end
   endtask

   task automatic wr_reg(logic [2:0] a, logic [7:0] d);
      @(negedge clk);
      addr = a; wdata = d; wr = 1'b1;
      @(negedge clk);
      wr = 1'b0;
   endtask

   task automatic rd_reg(logic [2:0] a, output logic [7:0] d);
      @(negedge clk);
      addr = a; rd = 1'b1;
      #1 d = rdata;
      @(negedge clk);
      rd = 1'b0;
   endtask

   task automatic send(logic [8:0] val, int n, bit pol);
      for (int i = 0; i < n; i++) begin
         ser_data = val[i];
         repeat (HALF) @(negedge clk);
         ser_clk = ~pol;
         repeat (HALF) @(negedge clk);
         ser_clk = pol;
      end
      repeat (8) @(negedge clk);
   endtask

   task automatic setup(bit nine, bit pol);
      wr_reg(3'd0, cfg(nine, pol, 1'b0, 1'b0, 1'b0));
      ser_clk = pol;
      repeat (8) @(negedge clk);
      wr_reg(3'd0, cfg(nine, pol, 1'b1, 1'b0, 1'b0));
   endtask

   initial begin
      repeat (150000) @(posedge clk);
      if (!finished) begin
         fails++;
         $display("FAIL watchdog expired");
         $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
         $finish;
      end
   end

   initial begin
      logic [7:0] r;
      logic [8:0] v;
      bit nine, pol;
      void'($urandom(32'h5eed1234));
      repeat (3) @(negedge clk);
      rst_n = 1'b1;
      @(negedge clk);

      // R1 reset state
      rd_reg(3'd0, r); check("R1 ctrl", r, 8'h00);
      rd_reg(3'd1, r); check("R1 stat", r, 8'h00);
      rd_reg(3'd2, r); check("R1 data", r, 8'h00);
      rd_reg(3'd3, r); check("R1 ien", r, 8'h00);
      rd_reg(3'd6, r); check("R1 unmapped", r, 8'h00);
      check("R1 irq", irq, 1'b0);
      check("R1 wake", wake, 1'b0);

      // R2 blocked configurations
      send(9'h0a5, 8, 1'b0);
      rd_reg(3'd1, r); check("R2 disabled", r, 8'h00);
      wr_reg(3'd0, cfg(1'b0, 1'b0, 1'b1, 1'b0, 1'b1));
      send(9'h05a, 8, 1'b0);
      rd_reg(3'd1, r); check("R2 master select", r, 8'h00);
      wr_reg(3'd0, 8'h12); // sync + cont, port enable clear
      send(9'h05a, 8, 1'b0);
      rd_reg(3'd1, r); check("R2 port disabled", r, 8'h00);

      // R6 single bit without continuous enable
      wr_reg(3'd0, cfg(1'b0, 1'b0, 1'b0, 1'b1, 1'b0));
      send(9'h0c3, 8, 1'b0);
      rd_reg(3'd1, r); check("R6 single alone", r, 8'h00);
      wr_reg(3'd0, cfg(1'b0, 1'b0, 1'b1, 1'b1, 1'b0));
      send(9'h0c3, 8, 1'b0);
      rd_reg(3'd1, r); check("R6 single+cont stat", r, stat_exp(1, 0, 0));
      rd_reg(3'd2, r); check("R6 single+cont data", r, 8'hc3);
      rd_reg(3'd1, r); check("R7 read clears flag", r, stat_exp(0, 0, 0));

      // R3 R4 R5 random words
      for (int k = 0; k < 24; k++) begin
         v    = 9'($urandom);
         nine = 1'($urandom);
         pol  = 1'($urandom);
         if (k == 0) begin nine = 0; pol = 0; end
         if (k == 1) begin nine = 1; pol = 1; v[8] = 1'b1; end
         setup(nine, pol);
         send(v, nine ? 9 : 8, pol);
         rd_reg(3'd1, r);
         check(nine ? "R4 stat ninth" : "R3 stat", r, stat_exp(1, 0, nine ? v[8] : 1'b0));
         rd_reg(3'd2, r);
         check(pol ? "R5 falling data" : "R5 rising data", r, v[7:0]);
         rd_reg(3'd1, r);
         check("R7 cleared", r[3], 1'b0);
      end

      // R8 overrun
      setup(1'b0, 1'b0);
      send(9'h011, 8, 1'b0);
      send(9'h022, 8, 1'b0);
      rd_reg(3'd1, r); check("R8 overrun stat", r, stat_exp(1, 1, 0));
      send(9'h033, 8, 1'b0);
      rd_reg(3'd2, r); check("R8 old word kept", r, 8'h11);
      send(9'h044, 8, 1'b0);
      rd_reg(3'd1, r); check("R8 blocked", r, stat_exp(0, 1, 0));

      // R9 clear by toggling continuous enable, restart after partial word
      wr_reg(3'd0, cfg(1'b0, 1'b0, 1'b0, 1'b0, 1'b0));
      rd_reg(3'd1, r); check("R9 overrun cleared", r, stat_exp(0, 0, 0));
      wr_reg(3'd0, cfg(1'b0, 1'b0, 1'b1, 1'b0, 1'b0));
      send(9'h1ff, 3, 1'b0);
      wr_reg(3'd0, cfg(1'b0, 1'b0, 1'b0, 1'b0, 1'b0));
      wr_reg(3'd0, cfg(1'b0, 1'b0, 1'b1, 1'b0, 1'b0));
      send(9'h096, 8, 1'b0);
      rd_reg(3'd1, r); check("R9 restart stat", r, stat_exp(1, 0, 0));

      // R10 R11 interrupt and wake gating with a pending word
      wr_reg(3'd3, 8'h01);
      sleep = 1'b1;
      @(negedge clk); #1;
      check("R10 rie only irq", irq, 1'b0);
      check("R11 wake while asleep", wake, 1'b1);
      sleep = 1'b0;
      @(negedge clk); #1;
      check("R11 no wake awake", wake, 1'b0);
      wr_reg(3'd3, 8'h03);
      #1 check("R10 no global", irq, 1'b0);
      wr_reg(3'd3, 8'h07);
      #1 check("R10 all enabled", irq, 1'b1);
      rd_reg(3'd3, r); check("R10 ien readback", r, 8'h07);
      rd_reg(3'd2, r); check("R9 restart data", r, 8'h96);
      @(negedge clk); #1;
      check("R10 irq drops after read", irq, 1'b0);
      sleep = 1'b1;
      @(negedge clk); #1;
      check("R11 no wake without flag", wake, 1'b0);
      sleep = 1'b0;

      finished = 1'b1;
      $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
      $finish;
   end

endmodule